// File: doc/BRIEF.md
# Bus-Holding Acknowledge Wait Controller

After a frame has left a node on a shared single-wire bus, the sender has to wait for the addressed node to answer with a synchronous response byte. This controller runs that wait. While it waits it keeps the wire visibly occupied, so no other node reads the wire as idle and starts a frame of its own. It drives a short high keep-alive pulse, one quarter of a data bit long, then releases the wire for one data bit plus one padding bit to listen. It repeats this pattern until the exchange is over.

When the controller sees the wire pulled high during a listen window, it takes this as the start of the responder's pad. It stops pulsing and waits for the byte receiver to deliver the byte. A received byte of value 6 finishes the wait as an acknowledge, and any other value finishes it as a negative acknowledge. If the per-application timeout, loaded in microseconds with the start strobe, runs out first, the wait ends as a timeout. In every case the wire is released. On the other side, the responder is expected to begin its reply after the falling edge of the last keep-alive pulse it sees.

Top module: `ack_wait_ctrl`

## Requirements
- R1: After reset the wire is not driven (`line_oe` = 0, `line_out` = 0), `busy` is 0, and all three status pulses are 0.
- R2: A `start` sampled while idle loads `timeout_us`. From the next cycle `busy` is 1 and the wire is driven high (`line_oe` = 1, `line_out` = 1).
- R3: Each keep-alive pulse lasts exactly DATA_BIT_US/4 microseconds, which is (DATA_BIT_US/4)*CLK_PER_US clock cycles.
- R4: After each pulse the wire is released for exactly (DATA_BIT_US+PAD_BIT_US)*CLK_PER_US cycles, and then another pulse follows.
- R5: A high level on `line_in` during a listen window ends pulsing. The wire then stays released until the wait terminates, even after `line_in` returns low.
- R6: While busy, `rx_valid` with `rx_byte` = 8'h06 ends the wait. At the next edge `done_ack` pulses for one cycle, `busy` falls and the wire is released.
- R7: While busy, `rx_valid` with any other `rx_byte` value ends the wait the same way, with `done_nack`.
- R8: With no byte received, `done_timeout` pulses and `busy` falls after exactly `timeout_us`*CLK_PER_US+1 busy cycles.
- R9: A `start` that arrives while busy has no effect. The wait keeps its original timeout.
- R10: Each wait produces exactly one status pulse. A byte that arrives in the same cycle the timeout expires takes precedence over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin waiting, one-cycle strobe |
| timeout_us | input | 32 | Response timeout in microseconds, captured on accepted start |
| line_in | input | 1 | Sampled wire level (asynchronous) |
| rx_valid | input | 1 | Byte receiver has a byte |
| rx_byte | input | 8 | Byte from the receiver |
| line_out | output | 1 | Level driven on the wire |
| line_oe | output | 1 | Wire driver enable |
| busy | output | 1 | Wait in progress |
| done_ack | output | 1 | Ended on acknowledge byte |
| done_nack | output | 1 | Ended on another byte |
| done_timeout | output | 1 | Ended on timeout |

## Verification
Two situations are hard to reach from the ports. The first is a received byte that lands in exactly the cycle the timeout counter reaches zero. The bench reaches it by counting `timeout_us`*CLK_PER_US edges from the accepted start before it raises `rx_valid`. The second is a responder pad that appears in the middle of a listen window and then drops. The bench raises `line_in` well inside the window, lowers it again, and watches several listen periods to confirm that no pulse resumes. Pulse and gap lengths are measured edge by edge with a scaled-down clock rate, so the cycle counts stay exact.

// File: rtl/ackw_pkg.sv
// Shared types and constants for the acknowledge wait controller.
// Assumes: nothing beyond IEEE 1800-2017.
package ackw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PULSE  = 2'd1,
        ST_LISTEN = 2'd2,
        ST_HEARD  = 2'd3
    } ackw_state_t;

    localparam logic [7:0] ACK_CODE = 8'h06;
endpackage

// File: rtl/ackw_us_tick.sv
// Microsecond prescaler: emits a one-cycle tick every CLK_PER_US cycles
// while run is high. clr restarts the count so that the first tick after
// a start falls exactly CLK_PER_US cycles later.
// Assumes: CLK_PER_US >= 1.
module ackw_us_tick #(
    parameter int CLK_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_q;

    assign tick = run && (pre_q == PRE_LAST);

    // Count clock cycles within one microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run || tick) pre_q <= '0;
        else                               pre_q <= pre_q + 1'b1;
    end

    // R3
    pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);
endmodule

// File: rtl/ackw_phase_timer.sv
// Measures the current keep-alive or listen phase in microsecond ticks.
// phase_end pulses on the tick that completes the selected length; the
// counter then wraps by itself, and it is also cleared on clr.
// Assumes: PULSE_US >= 1 and LISTEN_US >= 1.
module ackw_phase_timer #(
    parameter int PULSE_US  = 10,
    parameter int LISTEN_US = 132
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic sel_listen,
    output logic phase_end
);
    localparam int MAX_US = (LISTEN_US > PULSE_US) ? LISTEN_US : PULSE_US;
    localparam int PH_W   = $clog2(MAX_US + 1);

    logic [PH_W-1:0] cnt_q;
    logic [PH_W-1:0] len_m1;

    // Pick the length of the phase being timed.
    always_comb begin
        len_m1 = sel_listen ? PH_W'(LISTEN_US - 1) : PH_W'(PULSE_US - 1);
    end

    assign phase_end = tick && (cnt_q == len_m1);

    // Count elapsed microseconds in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || phase_end) cnt_q <= '0;
        else if (tick)                  cnt_q <= cnt_q + 1'b1;
    end

    // R4
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PH_W'(MAX_US - 1));
endmodule

// File: rtl/ackw_deadline.sv
// Response deadline: loads a microsecond count and decrements it on each
// tick while run is high. expired is high while the count is zero.
// Assumes: load only occurs when the controller is idle.
module ackw_deadline #(
    parameter int TO_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TO_W-1:0] load_val,
    input  logic            tick,
    input  logic            run,
    output logic            expired
);
    logic [TO_W-1:0] rem_q;

    assign expired = (rem_q == '0);

    // Hold the remaining time of the current wait.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rem_q <= '0;
        else if (load)                       rem_q <= load_val;
        else if (run && tick && !expired)    rem_q <= rem_q - 1'b1;
    end

    // R8
    rem_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> rem_q <= $past(rem_q));
endmodule

// File: rtl/ack_wait_ctrl.sv
// Sender-side wait for a synchronous response byte on a shared wire.
// It alternates quarter-bit high pulses with listen windows until the
// response pad is seen, then waits for the byte receiver. It ends on
// acknowledge, on another byte, or on the loaded timeout.
// Assumes: line_in is asynchronous (synchronised here); rx_valid/rx_byte
// are synchronous one-cycle strobes from a byte receiver.
module ack_wait_ctrl #(
    parameter int CLK_PER_US  = 100,
    parameter int DATA_BIT_US = 40,
    parameter int PAD_BIT_US  = 92,
    parameter int TO_W        = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [TO_W-1:0] timeout_us,
    input  logic            line_in,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    output logic            line_out,
    output logic            line_oe,
    output logic            busy,
    output logic            done_ack,
    output logic            done_nack,
    output logic            done_timeout
);
    import ackw_pkg::*;

    localparam int PULSE_US  = (DATA_BIT_US / 4 > 0) ? DATA_BIT_US / 4 : 1;
    localparam int LISTEN_US = DATA_BIT_US + PAD_BIT_US;

    ackw_state_t st_q, st_d;
    logic        sync1_q, line_hi_q;
    logic        start_acc, active, tick, phase_end, expired;

    assign active    = (st_q != ST_IDLE);
    assign start_acc = start && !active;

    // Bring the wire level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q   <= 1'b0;
            line_hi_q <= 1'b0;
        end else begin
            sync1_q   <= line_in;
            line_hi_q <= sync1_q;
        end
    end

    ackw_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(start_acc), .run(active), .tick(tick)
    );

    ackw_phase_timer #(.PULSE_US(PULSE_US), .LISTEN_US(LISTEN_US)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(st_q != st_d), .tick(tick),
        .sel_listen(st_q != ST_PULSE), .phase_end(phase_end)
    );

    ackw_deadline #(.TO_W(TO_W)) u_deadline (
        .clk(clk), .rst_n(rst_n), .load(start_acc), .load_val(timeout_us),
        .tick(tick), .run(active), .expired(expired)
    );

    // Choose the next phase of the wait.
    always_comb begin
        st_d = st_q;
        if (!active) begin
            if (start) st_d = ST_PULSE;
        end else if (rx_valid || expired) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_PULSE:  if (phase_end) st_d = ST_LISTEN;
                ST_LISTEN: begin
                    if (line_hi_q)      st_d = ST_HEARD;
                    else if (phase_end) st_d = ST_PULSE;
                end
                default:   st_d = st_q;
            endcase
        end
    end

    // Register the phase and the terminating status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            done_ack     <= 1'b0;
            done_nack    <= 1'b0;
            done_timeout <= 1'b0;
        end else begin
            st_q         <= st_d;
            done_ack     <= active && rx_valid && (rx_byte == ACK_CODE);
            done_nack    <= active && rx_valid && (rx_byte != ACK_CODE);
            done_timeout <= active && !rx_valid && expired;
        end
    end

    assign line_oe  = (st_q == ST_PULSE);
    assign line_out = (st_q == ST_PULSE);
    assign busy     = active;

    // R10
    one_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_ack, done_nack, done_timeout}));

    // R6
    release_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ack || done_nack || done_timeout) |-> (!line_oe && !busy));

    // R5
    heard_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HEARD) |=> (st_q == ST_HEARD || st_q == ST_IDLE));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start && !rx_valid && !expired) |=> busy);
endmodule

// File: tb/ack_wait_ctrl_bench.sv
module ack_wait_ctrl_bench;
    localparam int CPU    = 4;
    localparam int DBIT   = 8;
    localparam int PBIT   = 20;
    localparam int PULSE  = (DBIT / 4) * CPU;
    localparam int LISTEN = (DBIT + PBIT) * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] timeout_us = '0;
    logic        line_in = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        line_out, line_oe, busy, done_ack, done_nack, done_timeout;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    ack_wait_ctrl #(.CLK_PER_US(CPU), .DATA_BIT_US(DBIT), .PAD_BIT_US(PBIT)) u_ack_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .timeout_us(timeout_us),
        .line_in(line_in), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .line_out(line_out), .line_oe(line_oe), .busy(busy),
        .done_ack(done_ack), .done_nack(done_nack), .done_timeout(done_timeout)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Ends at the negedge following the accepting edge.
    task automatic do_start(input int t);
        @(negedge clk);
        start = 1'b1;
        timeout_us = t;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 oe", line_oe, 0);
        check("R1 out", line_out, 0);
        check("R1 busy", busy, 0);
        check("R1 status", done_ack | done_nack | done_timeout, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_pulse_train;
        int w = 0;
        int g = 0;
        int w2 = 0;
        do_start(1000);
        check("R2 busy", busy, 1);
        check("R2 line", {line_oe, line_out}, 3);
        while (line_oe) begin w++; @(negedge clk); end
        while (!line_oe) begin g++; @(negedge clk); end
        while (line_oe) begin w2++; @(negedge clk); end
        check("R3 width", w, PULSE);
        check("R4 gap", g, LISTEN);
        check("R4 repeat width", w2, PULSE);
        send_byte(8'h06);
        check("R6 ack after train", done_ack, 1);
    endtask

    task automatic t_ack;
        do_start(1000);
        repeat (30) @(negedge clk);
        send_byte(8'h06);
        check("R6 done_ack", done_ack, 1);
        check("R6 busy/oe", {busy, line_oe}, 0);
        check("R6 only ack", done_nack | done_timeout, 0);
        @(negedge clk);
        check("R6 one cycle", done_ack, 0);
    endtask

    task automatic t_nack;
        do_start(1000);
        repeat (40) @(negedge clk);
        send_byte(8'h07);
        check("R7 done_nack", done_nack, 1);
        check("R7 not ack", done_ack, 0);
        check("R7 released", {busy, line_oe}, 0);
    endtask

    task automatic t_timeout;
        int n = 0;
        do_start(50);
        while (busy) begin n++; @(negedge clk); end
        check("R8 busy cycles", n, 50 * CPU + 1);
        check("R8 done_timeout", done_timeout, 1);
        check("R8 released", line_oe, 0);
    endtask

    task automatic t_heard;
        int pulses = 0;
        do_start(1000);
        repeat (PULSE + 30) @(negedge clk);
        line_in = 1'b1;
        repeat (40) @(negedge clk);
        line_in = 1'b0;
        repeat (3 * LISTEN) begin
            if (line_oe) pulses++;
            @(negedge clk);
        end
        check("R5 no pulses after pad", pulses, 0);
        check("R5 still busy", busy, 1);
        send_byte(8'h06);
        check("R5 ends with ack", done_ack, 1);
    endtask

    task automatic t_restart_ignored;
        int n = 0;
        do_start(50);
        while (busy) begin
            n++;
            if (n == 20) begin start = 1'b1; timeout_us = 1000; end
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check("R9 original timeout kept", n, 50 * CPU + 1);
        check("R9 single timeout", done_timeout, 1);
    endtask

    task automatic t_priority;
        do_start(10);
        repeat (10 * CPU) @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = 8'h06;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
        check("R10 byte wins", done_ack, 1);
        check("R10 no timeout", done_timeout, 0);
        check("R10 idle", busy, 0);
    endtask

    initial begin
        t_reset();
        t_pulse_train();
        t_ack();
        t_nack();
        t_timeout();
        t_heard();
        t_restart_ignored();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule